// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Logic

This block wraps a small sum-of-terms logic core of macrocells and adds a standby mode driven by one dedicated pin. A configuration input picks what that pin does. With standby disabled the pin is one more term of the logic array. With standby enabled, sampling the pin high at a clock edge freezes the block. The array inputs and the output-enable bits are latched at that edge, and the macrocell registers stop updating. The data and enable outputs then hold their last values, whatever happens on the other inputs or the clock.

Each macrocell forms the parity of a parameter-selected subset of the array vector. The array vector is made of the core inputs, the pin term and the buried register feedback. A macrocell drives out either its register or its combinational sum, with an optional inversion. When the pin is seen low again, the block counts a parameterised number of recovery edges before it honours inputs and the clock again. A `ready` output shows when the block is live.

The controller has three named states. ST_ACTIVE is live operation. ST_DOWN is frozen. ST_WAKE is frozen while the recovery edges are counted. These are the transitions:
- enter: ST_ACTIVE to ST_DOWN when standby is enabled and the pin is sampled high.
- release: ST_DOWN to ST_WAKE when that request is sampled low.
- relapse: ST_WAKE to ST_DOWN when the request is sampled high again.
- resume: ST_WAKE to ST_ACTIVE on the last recovery edge.

Top module: `pdhold_top`

## Requirements
- R1: After reset the registers are 0, `ready` is 1, and with all inputs 0 `out_data` is 4'b0100 while `out_oe` follows `core_oe`.
- R2: While live, macrocell i computes the parity of the array vector {q[3:0], pin term, core_in[5:0]} ANDed with its term mask. The masks are 11'h083, 11'h0C4, 11'h418 and 11'h060 for i = 0..3. All registers q load their sum on each live edge. Macrocells 0 and 2 drive q and macrocells 1 and 3 drive the sum. Macrocell 2's output is inverted.
- R3: With `pd_en` low, `pd_pin` is the pin term of the array, and the block never leaves the live state.
- R4: With `pd_en` high, the pin term reads 0. Buried register feedback still reaches the array.
- R5: In ST_ACTIVE, an edge that samples `pd_en` and `pd_pin` high moves the block to ST_DOWN, drops `ready` and does not update any register.
- R6: While `ready` is low, `out_data` and `out_oe` hold the values given by the inputs and enables latched at the entry edge. Changes on `core_in` and `core_oe` have no effect.
- R7: No clock edge updates a macrocell register while the block is in ST_DOWN or ST_WAKE.
- R8: The edge that samples the request low moves ST_DOWN to ST_WAKE. `ready` rises after exactly RECOVER (3) further edges, and inputs stay blocked until then.
- R9: A request sampled high in ST_WAKE returns the block to ST_DOWN. A later release restarts the full recovery count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_en | input | 1 | 1: pin is a standby control; 0: pin is a logic term |
| pd_pin | input | 1 | Standby request or logic input |
| core_in | input | N_IN | Logic array inputs |
| core_oe | input | N_MC | Per-macrocell output enables |
| out_data | output | N_MC | Macrocell outputs, held in standby |
| out_oe | output | N_MC | Output enables, held in standby |
| ready | output | 1 | High when inputs and clock are honoured |

## Verification
Combinational macrocell outputs respond in the same cycle as the input change. Registered outputs, `ready` and the frozen values change one edge after the sampling edge. `ready` returns RECOVER edges after the release edge. The bench drives every input at the falling clock edge and checks combinational results 1 ns later, before the next rising edge. It checks registered results at the falling edge that follows the rising edge under test. A reference model in the bench steps once per rising edge, so each comparison lands in the cycle where the result is due. During recovery the bench checks `ready` and the held outputs after every edge, so an early or late resume is seen on the exact edge.

// File: rtl/pdhold_pkg.sv
package pdhold_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_DOWN   = 2'd1,
        ST_WAKE   = 2'd2
    } pd_state_e;
endpackage

// File: rtl/pdhold_ctrl.sv
module pdhold_ctrl
    import pdhold_pkg::*;
#(
    parameter int RECOVER = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_en,
    input  logic pd_pin,
    output logic active,
    output logic upd
);
    localparam int CW = (RECOVER > 1) ? $clog2(RECOVER) : 1;
    localparam logic [CW-1:0] LAST = CW'(RECOVER - 1);

    pd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic pd_req;

    assign pd_req = pd_en & pd_pin;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ACTIVE: if (pd_req) state_d = ST_DOWN;
            ST_DOWN: begin
                if (!pd_req) begin
                    state_d = ST_WAKE;
                    cnt_d   = '0;
                end
            end
            ST_WAKE: begin
                if (pd_req)              state_d = ST_DOWN;
                else if (cnt_q == LAST)  state_d = ST_ACTIVE;
                else                     cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active = (state_q == ST_ACTIVE);
        upd    = active & ~pd_req;
    end

    a_r5_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && pd_req) |=> (state_q == ST_DOWN));
    a_r3_stay_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !pd_en) |=> (state_q == ST_ACTIVE));
    a_r9_relapse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && pd_req) |=> (state_q == ST_DOWN));
    a_r8_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !pd_req && cnt_q != LAST) |=> (state_q == ST_WAKE));
endmodule

// File: rtl/pdhold_gate.sv
module pdhold_gate #(
    parameter int N_IN = 6,
    parameter int N_MC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            pd_en,
    input  logic            pd_pin,
    input  logic [N_IN-1:0] core_in,
    input  logic [N_MC-1:0] core_oe,
    output logic [N_IN-1:0] arr_in,
    output logic            pd_term,
    output logic [N_MC-1:0] oe_eff
);
    logic [N_IN-1:0] hin_q;
    logic [N_MC-1:0] hoe_q;
    logic            hpd_q;
    logic            live_pd;

    assign live_pd = pd_pin & ~pd_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hin_q <= '0;
            hoe_q <= '0;
            hpd_q <= 1'b0;
        end else if (active) begin
            hin_q <= core_in;
            hoe_q <= core_oe;
            hpd_q <= live_pd;
        end
    end

    always_comb begin
        arr_in  = active ? core_in : hin_q;
        oe_eff  = active ? core_oe : hoe_q;
        pd_term = active ? live_pd : hpd_q;
    end

    a_r6_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (active || $stable(oe_eff)));
    a_r6_in_held: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (active || $stable(arr_in)));
endmodule

// File: rtl/pdhold_array.sv
module pdhold_array #(
    parameter int N_IN = 6,
    parameter int N_MC = 4,
    parameter int A_W  = N_IN + 1 + N_MC,
    parameter logic [N_MC*A_W-1:0] TERM_MASK = '0,
    parameter logic [N_MC-1:0]     REG_MASK  = '0,
    parameter logic [N_MC-1:0]     INV_MASK  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [N_IN-1:0] arr_in,
    input  logic            pd_term,
    output logic [N_MC-1:0] out_data
);
    logic [N_MC-1:0] q;
    logic [N_MC-1:0] sum;
    logic [A_W-1:0]  avec;

    assign avec = {q, pd_term, arr_in};

    for (genvar i = 0; i < N_MC; i++) begin : g_mc
        assign sum[i] = ^(avec & TERM_MASK[i*A_W +: A_W]);
        if (REG_MASK[i]) begin : g_reg
            assign out_data[i] = q[i] ^ INV_MASK[i];
        end else begin : g_comb
            assign out_data[i] = sum[i] ^ INV_MASK[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (upd) q <= sum;
    end

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));
endmodule

// File: rtl/pdhold_top.sv
module pdhold_top #(
    parameter int N_IN    = 6,
    parameter int N_MC    = 4,
    parameter int RECOVER = 3,
    parameter int A_W     = N_IN + 1 + N_MC,
    parameter logic [N_MC*A_W-1:0] TERM_MASK = {11'h060, 11'h418, 11'h0C4, 11'h083},
    parameter logic [N_MC-1:0]     REG_MASK  = 4'b0101,
    parameter logic [N_MC-1:0]     INV_MASK  = 4'b0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_en,
    input  logic            pd_pin,
    input  logic [N_IN-1:0] core_in,
    input  logic [N_MC-1:0] core_oe,
    output logic [N_MC-1:0] out_data,
    output logic [N_MC-1:0] out_oe,
    output logic            ready
);
    logic            active;
    logic            upd;
    logic [N_IN-1:0] arr_in;
    logic            pd_term;

    pdhold_ctrl #(.RECOVER(RECOVER)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .pd_pin(pd_pin),
        .active(active), .upd(upd)
    );

    pdhold_gate #(.N_IN(N_IN), .N_MC(N_MC)) u_gate (
        .clk(clk), .rst_n(rst_n), .active(active), .pd_en(pd_en),
        .pd_pin(pd_pin), .core_in(core_in), .core_oe(core_oe),
        .arr_in(arr_in), .pd_term(pd_term), .oe_eff(out_oe)
    );

    pdhold_array #(
        .N_IN(N_IN), .N_MC(N_MC), .A_W(A_W),
        .TERM_MASK(TERM_MASK), .REG_MASK(REG_MASK), .INV_MASK(INV_MASK)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .upd(upd), .arr_in(arr_in),
        .pd_term(pd_term), .out_data(out_data)
    );

    assign ready = active;

    a_r6_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready || $stable(out_data)));
endmodule

// File: tb/pdhold_top_tb.sv
module pdhold_top_tb;
    localparam int CLK_P = 10;
    localparam int RECOVER = 3;
    localparam logic [10:0] M0 = 11'h083, M1 = 11'h0C4, M2 = 11'h418, M3 = 11'h060;
    localparam logic [3:0] REGM = 4'b0101, INVM = 4'b0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_en = 1'b0, pd_pin = 1'b0;
    logic [5:0] core_in = '0;
    logic [3:0] core_oe = '0;
    logic [3:0] out_data, out_oe;
    logic ready;

    int errors = 0, checks = 0;
    bit done = 0;

    // reference model state
    logic [3:0] m_q = '0;
    int m_mode = 0;            // 0 live, 1 down, 2 wake
    int m_cnt = 0;
    logic [5:0] m_hin = '0;
    logic [3:0] m_hoe = '0;
    logic m_hpd = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pdhold_top u_dut (
        .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .pd_pin(pd_pin),
        .core_in(core_in), .core_oe(core_oe),
        .out_data(out_data), .out_oe(out_oe), .ready(ready)
    );

    function automatic logic [3:0] f_sum(logic [5:0] a_in, logic pt, logic [3:0] q);
        logic [10:0] v;
        v = {q, pt, a_in};
        return {^(v & M3), ^(v & M2), ^(v & M1), ^(v & M0)};
    endfunction

    function automatic logic [3:0] f_out(logic [5:0] a_in, logic pt, logic [3:0] q);
        return (((q & REGM) | (f_sum(a_in, pt, q) & ~REGM)) ^ INVM);
    endfunction

    task automatic chk(string tag);
        logic [3:0] e_d, e_oe;
        logic e_r;
        if (m_mode == 0) begin
            e_d  = f_out(core_in, pd_pin & ~pd_en, m_q);
            e_oe = core_oe;
        end else begin
            e_d  = f_out(m_hin, m_hpd, m_q);
            e_oe = m_hoe;
        end
        e_r = (m_mode == 0);
        checks++;
        if (out_data !== e_d || out_oe !== e_oe || ready !== e_r) begin
            errors++;
            $display("FAIL %s: data=%b oe=%b ready=%b expected data=%b oe=%b ready=%b",
                     tag, out_data, out_oe, ready, e_d, e_oe, e_r);
        end
    endtask

    // one rising edge, model stepped in step with it
    task automatic tick();
        logic preq;
        preq = pd_en & pd_pin;
        case (m_mode)
            0: begin
                m_hin = core_in; m_hoe = core_oe; m_hpd = pd_pin & ~pd_en;
                if (preq) m_mode = 1;
                else      m_q = f_sum(core_in, pd_pin & ~pd_en, m_q);
            end
            1: if (!preq) begin m_mode = 2; m_cnt = 0; end
            default: begin
                if (preq) m_mode = 1;
                else if (m_cnt == RECOVER - 1) m_mode = 0;
                else m_cnt++;
            end
        endcase
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(logic [5:0] i, logic [3:0] oe);
        core_in = i; core_oe = oe;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 reset");
        checks++;
        if (out_data !== 4'b0100) begin
            errors++;
            $display("FAIL R1: data=%b expected 0100", out_data);
        end
    endtask

    task automatic t_live();
        logic [5:0] pats [6] = '{6'h03, 6'h01, 6'h18, 6'h2A, 6'h3F, 6'h00};
        pd_en = 0; pd_pin = 0;
        foreach (pats[k]) begin
            drive(pats[k], 4'(k));
            chk("R2 comb");
            tick();
            chk("R2 reg");
        end
    endtask

    task automatic t_pin_input();
        pd_en = 0; pd_pin = 1;
        for (int k = 0; k < 4; k++) begin
            drive(6'(k * 9), 4'b1001);
            chk("R3 pin term");
            tick();
            chk("R3 stays live");
        end
        pd_pin = 0; #1;
        chk("R3 pin low");
    endtask

    task automatic t_pin_masked();
        pd_en = 1; pd_pin = 0;
        drive(6'h21, 4'b0011);
        tick();
        chk("R4 feedback live");
        pd_pin = 1; #1;
        chk("R4 pin term zero");
    endtask

    task automatic t_entry_hold();
        // pd_pin high from t_pin_masked: this edge enters standby
        tick();
        chk("R5 entry");
        for (int k = 0; k < 5; k++) begin
            drive(6'(k * 13 + 5), 4'(~k));
            chk("R6 held");
            tick();
            chk("R7 no update");
        end
    endtask

    task automatic t_wake();
        pd_pin = 0; #1;
        tick();
        chk("R8 release");
        for (int k = 0; k < RECOVER; k++) begin
            drive(6'(k * 7 + 2), 4'(k + 5));
            chk("R8 blocked");
            tick();
            chk("R8 recovery edge");
        end
        checks++;
        if (ready !== 1'b1) begin
            errors++;
            $display("FAIL R8: ready=%b expected 1 after %0d edges", ready, RECOVER);
        end
        drive(6'h15, 4'b1111);
        tick();
        chk("R8 live again");
    endtask

    task automatic t_relapse();
        pd_pin = 1; #1;
        tick();
        chk("R9 down");
        pd_pin = 0; #1;
        tick();
        tick();
        chk("R9 in wake");
        pd_pin = 1; #1;
        tick();
        chk("R9 relapse");
        pd_pin = 0; #1;
        tick();
        for (int k = 0; k < RECOVER; k++) begin
            drive(6'(k + 40), 4'(k));
            tick();
            chk("R9 full recount");
        end
        drive(6'h0C, 4'b0110);
        tick();
        chk("R9 live");
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 R2 R3 R4 R5 R6 R7 R8 R9: timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_live();
        t_pin_input();
        t_pin_masked();
        t_entry_hold();
        t_wake();
        t_relapse();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule